// File: doc/BRIEF.md
# PCI Configuration Window Address Decoder

This block sits behind a 4 MiB window in CPU memory space. It turns each CPU load or store that lands in the window into one configuration-space cycle on a downstream port. The CPU side presents a window offset, an access size and write data on a valid/ready request channel. The block answers with a one-cycle response pulse that carries the read data.

The target device is not taken from a binary field of the offset. Offset lines 11 and up act as one-hot select lines. The lowest line that is set gives the device number. When none is set, the device number is one past the last line. The low eleven offset bits pass through unchanged as the function and register part of the configuration address. Data lanes are little-endian, and reads and writes use the same translation.

Only one transaction is in flight at a time. The CPU side stalls until the downstream port acknowledges. An offset beyond the window is answered locally and never reaches the downstream port.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and `cfg_req` and `cpu_rsp_valid` are 0.
- R2: `cfg_addr[10:0]` equals offset bits [10:0] of the accepted request.
- R3: `cfg_addr[14:11]` holds the device number. This is the index k (0 to 10) of the lowest offset bit 11+k that is set among bits 11 to 21. Higher set bits are ignored.
- R4: When none of offset bits 11 to 21 is set, the device number is 11.
- R5: Size code 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. `cfg_be` is the size mask (0001, 0011 or 1111) shifted left by offset bits [1:0]. Enables beyond lane 3 are dropped.
- R6: `cfg_wdata` is `cpu_wdata` shifted up by 8 times offset bits [1:0], little-endian: lane k is bits [8k+7:8k]. `cfg_we` follows `cpu_we`.
- R7: Read data is `cfg_rdata` shifted down by 8 times offset bits [1:0]. Bits above the access size are zero.
- R8: From acceptance until the response, `cpu_req_ready` is 0. `cfg_req` stays 1 with stable address, enables, data and direction until `cfg_ack`.
- R9: `cpu_rsp_valid` is a single-cycle pulse in the cycle after the `cfg_req`/`cfg_ack` handshake.
- R10: An accepted offset with bit 22 set lies outside the window. No `cfg_req` is raised, and the response comes in the cycle after acceptance. A read returns all ones.
- R11: The response to a write carries `cpu_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block idle and accepting |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ofs | input | 23 | Offset within the window |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rdata | output | 32 | Read data, right-aligned |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 15 | Device number and register offset |
| cfg_be | output | 4 | Byte lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Lane-aligned read data |

## Verification
A wrong device index shows up in `cfg_addr[14:11]` in the first cycle of the downstream request. The same is true of a wrong lane shift or a wrong enable mask, in `cfg_be` or `cfg_wdata`. These are visible before any acknowledge. A broken sequencer shows within a few cycles in three ways: `cpu_req_ready` returns while the request is still pending, the response pulse is missing or lasts two cycles, or `cfg_req` appears for an out-of-window offset. Read-path errors surface in the single response cycle that follows the acknowledge.

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder #(
  parameter int OFS_W  = 23,
  parameter int WIN_W  = 22,
  parameter int LOW_W  = 11,
  parameter int DEV_W  = $clog2(WIN_W - LOW_W + 1),
  parameter int ADDR_W = LOW_W + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_we,
  input  logic [OFS_W-1:0]  cpu_ofs,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic [31:0]       cfg_rdata
);
  localparam int NSEL = WIN_W - LOW_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;
  state_t state;

  logic [DEV_W-1:0] dev;
  logic [3:0]       mask;
  logic [6:0]       be_wide;
  logic [1:0]       lane;
  logic             in_win;
  logic             accept;
  logic [1:0]       lane_q;
  logic [1:0]       size_q;
  logic [31:0]      rd_sh;

  assign lane    = cpu_ofs[1:0];
  assign in_win  = (cpu_ofs >> WIN_W) == '0;
  assign accept  = cpu_req_valid && cpu_req_ready;
  assign be_wide = {3'b000, mask} << lane;
  assign rd_sh   = cfg_rdata >> (8 * lane_q);

  always_comb begin
    dev = DEV_W'(NSEL);
    for (int i = NSEL - 1; i >= 0; i--)
      if (cpu_ofs[LOW_W + i]) dev = DEV_W'(i);
  end

  always_comb begin
    case (cpu_size)
      2'd0:    mask = 4'b0001;
      2'd1:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end

  assign cpu_req_ready = (state == S_IDLE);
  assign cpu_rsp_valid = (state == S_RSP);
  assign cfg_req       = (state == S_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      cpu_rdata <= '0;
      lane_q    <= '0;
      size_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          cfg_we    <= cpu_we;
          cfg_addr  <= {dev, cpu_ofs[LOW_W-1:0]};
          cfg_be    <= be_wide[3:0];
          cfg_wdata <= cpu_wdata << (8 * lane);
          lane_q    <= lane;
          size_q    <= cpu_size;
          cpu_rdata <= (in_win || cpu_we) ? 32'h0 : 32'hFFFF_FFFF;
          state     <= in_win ? S_REQ : S_RSP;
        end
        S_REQ: if (cfg_ack) begin
          if (cfg_we)             cpu_rdata <= 32'h0;
          else if (size_q == 2'd0) cpu_rdata <= {24'h0, rd_sh[7:0]};
          else if (size_q == 2'd1) cpu_rdata <= {16'h0, rd_sh[15:0]};
          else                     cpu_rdata <= rd_sh;
          state <= S_RSP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_window_chk #(
  parameter int OFS_W  = 23,
  parameter int WIN_W  = 22,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic [OFS_W-1:0]  cpu_ofs,
  input logic              cpu_rsp_valid,
  input logic              cfg_req,
  input logic              cfg_ack,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_be)
                            && $stable(cfg_wdata) && $stable(cfg_we));
  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !cpu_req_ready);
  // R9
  rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> cpu_rsp_valid);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
  // R10
  outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && ((cpu_ofs >> WIN_W) != '0)
      |=> !cfg_req && cpu_rsp_valid);
  // R5
  be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_be != 4'b0000);
endmodule

bind cfg_window_decoder cfg_window_chk #(.OFS_W(OFS_W), .WIN_W(WIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_ofs(cpu_ofs), .cpu_rsp_valid(cpu_rsp_valid), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata));

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_we = 1'b0;
  logic [22:0] cpu_ofs = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rdata;
  logic        cfg_req;
  logic        cfg_we;
  logic [14:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_window_decoder dut (.*);

  localparam int NV = 10;
  localparam logic [22:0] V_OFS [NV] = '{23'h000800, 23'h001004, 23'h200000, 23'h000000, 23'h0C0003,
                                        23'h004802, 23'h010001, 23'h3FFFFF, 23'h1007FD, 23'h020010};
  localparam logic [1:0]  V_SZ  [NV] = '{2, 2, 2, 0, 0, 1, 1, 2, 3, 0};
  localparam logic        V_WE  [NV] = '{0, 0, 1, 0, 0, 1, 0, 1, 0, 1};
  localparam logic [31:0] V_WD  [NV] = '{0, 0, 32'h01020304, 0, 0, 32'h0000BEEF, 0, 32'h11223344, 0, 32'h000000A5};
  localparam logic [31:0] V_RD  [NV] = '{32'h11223344, 32'h55667788, 0, 32'h9ABCDEF0, 32'hAABBCCDD,
                                        0, 32'h12345678, 0, 32'hCAFEF00D, 0};
  localparam int          V_DLY [NV] = '{0, 1, 2, 0, 3, 1, 0, 2, 1, 3};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dev(logic [22:0] o);
    for (int k = 10; k >= 0; k--) ;
    for (int k = 0; k <= 10; k++) if (o[11 + k]) return 4'(k);
    return 4'd11;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] ln);
    logic [6:0] m;
    m = (sz == 0) ? 7'h1 : (sz == 1) ? 7'h3 : 7'hF;
    m = m << ln;
    return m[3:0];
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] d, logic [1:0] sz, logic [1:0] ln);
    logic [31:0] s;
    s = d >> (8 * ln);
    if (sz == 0) s &= 32'hFF;
    else if (sz == 1) s &= 32'hFFFF;
    return s;
  endfunction

  task automatic access(logic we, logic [22:0] o, logic [1:0] sz, logic [31:0] wd,
                        logic [31:0] rd, int dly);
    @(negedge clk);
    check("R8 ready when idle", 32'(cpu_req_ready), 32'd1);
    cpu_req_valid = 1; cpu_we = we; cpu_ofs = o; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    if (o[22]) begin
      check("R10 no cfg_req outside window", 32'(cfg_req), 32'd0);
      check("R10 response next cycle", 32'(cpu_rsp_valid), 32'd1);
      check(we ? "R11 write rdata zero" : "R10 read all ones", cpu_rdata, we ? 32'h0 : 32'hFFFFFFFF);
    end else begin
      check("R8 cfg_req raised", 32'(cfg_req), 32'd1);
      check("R2 low offset bits", 32'(cfg_addr[10:0]), 32'(o[10:0]));
      check("R3 R4 device number", 32'(cfg_addr[14:11]), 32'(exp_dev(o)));
      check("R5 byte enables", 32'(cfg_be), 32'(exp_be(sz, o[1:0])));
      check("R6 direction", 32'(cfg_we), 32'(we));
      if (we) check("R6 lane data", cfg_wdata, wd << (8 * o[1:0]));
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        check("R8 stall while pending", 32'({cpu_req_ready, cfg_req, cpu_rsp_valid}), 32'b010);
      end
      cfg_ack = 1; cfg_rdata = rd;
      @(negedge clk);
      cfg_ack = 0; cfg_rdata = 32'h0;
      check("R9 response after ack", 32'({cpu_rsp_valid, cfg_req}), 32'b10);
      check(we ? "R11 write rdata zero" : "R7 read data", cpu_rdata, we ? 32'h0 : exp_rd(rd, sz, o[1:0]));
    end
    @(negedge clk);
    check("R9 single pulse", 32'({cpu_rsp_valid, cpu_req_ready}), 32'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(cpu_req_ready), 32'd1);
    check("R1 reset cfg_req", 32'(cfg_req), 32'd0);
    check("R1 reset rsp", 32'(cpu_rsp_valid), 32'd0);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      access(V_WE[i], V_OFS[i], V_SZ[i], V_WD[i], V_RD[i], V_DLY[i]);
    access(0, 23'h400000, 2, 0, 0, 0);
    access(1, 23'h7FFFFF, 2, 32'hFFFFFFFF, 0, 0);
    access(0, 23'h400800, 0, 0, 0, 0);
    access(0, 23'h000002, 1, 0, 32'h89ABCDEF, 0);
    access(0, 23'h200FFF, 2, 0, 32'h76543210, 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule